// File: doc/BRIEF.md
# SD Card Clock Divider with Launch-Edge Select

This block turns a kernel clock into the clock driven to an SD or MMC card, and it tells the command and data paths when to drive. A 10-bit divide value `div_val` sets the card clock rate. For a non-zero value N, the card clock stays high for N kernel cycles and low for N kernel cycles, so the kernel rate is divided by 2N. A value of zero selects bypass: the kernel clock goes straight out, and outputs launch on its falling edge. In divided mode, a negative-edge select picks whether the command and data outputs launch on the rising or the falling card-clock edge.

Besides the clock, the block produces two kernel-domain strobes. `clk_en` marks each card-clock rising edge. `launch_stb` marks the edge on which the command and data paths should change their outputs. The divide value and the edge select are held in shadow registers that reload only at a card-clock falling edge, or while the card clock is parked low. A setting written in mid-phase therefore cannot shorten a pulse. The card clock parks low in three cases: the power sequencer has not granted run, power-save is on while the bus is idle, or flow control asks for a stall. A bus-width code is turned into a per-lane enable mask for the data pins.

Top module: `sdclk_gen`

## Requirements
- R1: During and right after reset, `card_clk`, `clk_en` and `launch_stb` are low and `lane_en` is 8'h01.
- R2: With a non-zero divide value N and the clock running, `card_clk` is high for exactly N kernel cycles and then low for exactly N kernel cycles. This holds for any N from 1 to 1023.
- R3: With a divide value of 0 and the clock running, `card_clk` follows the kernel clock (high in its high phase, low in its low phase). `clk_en` and `launch_stb` are high in every kernel cycle.
- R4: In divided mode, `clk_en` is high for the one kernel cycle in which `card_clk` has just risen. With `neg_edge`=0, `launch_stb` is high in that same cycle. With `neg_edge`=1, `launch_stb` is high instead in the one cycle in which `card_clk` has just fallen.
- R5: A change of divide value or edge select takes effect at the next card-clock falling edge. The high phase in progress completes with the old value, and the following low phase uses the new one.
- R6: When `run_en` is low, `card_clk` is low and the strobes are idle. In divided mode this starts from the next kernel edge. In bypass it starts from the next kernel-clock low phase.
- R7: With `pwr_save`=1 and `bus_busy`=0, the card clock finishes any high phase in progress and then holds low with no `clk_en`. Once `bus_busy` rises, the next rising edge comes N kernel edges after the release is seen.
- R8: A high `fifo_stall` parks the card clock low in the same way as R7, after any high phase in progress completes. On release, it resumes with the same timing as R7.
- R9: `width_sel` bit 0 selects 4-bit mode and bit 1 selects 8-bit mode; bit 1 wins if both are set. `lane_en` is 8'h01 for 1-bit mode, 8'h0F for 4-bit mode and 8'hFF for 8-bit mode, and is registered with one kernel cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Power sequencer grants clock output |
| div_val | input | 10 | Divide value; 0 selects bypass |
| neg_edge | input | 1 | In divided mode, launch on the falling card edge |
| pwr_save | input | 1 | Stop the card clock while the bus is idle |
| bus_busy | input | 1 | Command or data transfer in progress |
| fifo_stall | input | 1 | Flow-control request to stop the card clock |
| width_sel | input | 2 | Bus width code: bit 0 = 4-bit, bit 1 = 8-bit |
| card_clk | output | 1 | Clock to the card |
| clk_en | output | 1 | Pulse marking a card-clock rising edge |
| launch_stb | output | 1 | Pulse marking the output launch edge |
| lane_en | output | 8 | Enable mask for the data lanes |

## Verification
The divider reload and the clock-stop request can fall in the same cycle. A new divide value arrives during a high phase while a stall or power-save request also arrives, and both act at the same falling edge. The bench provokes the reload case by writing a new divide value one cycle after a rising edge. It then judges three phase lengths: the high phase in progress must keep the old length, and the next low and high phases must take the new one. The stop cases are judged the same way: the high phase in progress keeps its full length, the clock then stays parked, and the low phase after release is measured.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;

  localparam int unsigned CFG_DIV_W  = 10;
  localparam int unsigned CFG_LANES  = 8;
  localparam int unsigned NARROW_LN  = 4;

  // last count of a half period for a non-zero divide value
  function automatic logic [CFG_DIV_W-1:0] half_last(input logic [CFG_DIV_W-1:0] dv);
    return dv - 1'b1;
  endfunction

  // a zero divide value means pass the kernel clock through
  function automatic logic is_bypass(input logic [CFG_DIV_W-1:0] dv);
    return (dv == '0);
  endfunction

  // lane enable for one data lane; code bit1 = 8-bit wins over bit0 = 4-bit
  function automatic logic lane_pick(input int idx, input logic [1:0] code);
    return (idx == 0) || code[1] || (code[0] && (idx < NARROW_LN));
  endfunction

  // clock may run: power granted, no stall, not idling under power save
  function automatic logic clock_go(input logic run, input logic stall,
                                    input logic save, input logic busy);
    return run && !stall && !(save && !busy);
  endfunction

endpackage

// File: rtl/sdclk_shadow.sv
`timescale 1ns/1ps
module sdclk_shadow
  import sdclk_pkg::*;
#(
  parameter int unsigned DIV_W = CFG_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             q_div,
  input  logic [DIV_W-1:0] div_in,
  input  logic             neg_in,
  output logic [DIV_W-1:0] cfg_div,
  output logic             cfg_neg,
  output logic             byp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div <= '0;
      cfg_neg <= 1'b0;
    end else if (load) begin
      cfg_div <= div_in;
      cfg_neg <= neg_in;
    end
  end

  assign byp = is_bypass(cfg_div);

  // R5: the active divide value only changes while the card clock is low
  a_r5_reload_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_div) |-> !q_div);

endmodule

// File: rtl/sdclk_divcore.sv
`timescale 1ns/1ps
module sdclk_divcore
  import sdclk_pkg::*;
#(
  parameter int unsigned DIV_W = CFG_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             go,
  input  logic             byp,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_neg,
  output logic             q_div,
  output logic             rise_q,
  output logic             lch_q,
  output logic             low_bound
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_m1;
  logic             at_end;
  logic             parked;

  assign div_m1    = half_last(cfg_div);
  assign at_end    = (cnt_q == div_m1);
  assign parked    = !q_div && !go;
  // safe points for a reload: clock low now or falling at this edge
  assign low_bound = byp || !run_en || parked || (q_div && at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      q_div  <= 1'b0;
      rise_q <= 1'b0;
      lch_q  <= 1'b0;
    end else if (byp || !run_en) begin
      cnt_q  <= '0;
      q_div  <= 1'b0;
      rise_q <= 1'b0;
      lch_q  <= 1'b0;
    end else if (parked) begin
      cnt_q  <= '0;
      rise_q <= 1'b0;
      lch_q  <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      q_div  <= !q_div;
      rise_q <= !q_div;
      lch_q  <= q_div ? cfg_neg : !cfg_neg;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      rise_q <= 1'b0;
      lch_q  <= 1'b0;
    end
  end

  // R6: no power grant forces the divided clock low at the next edge
  a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !q_div);

  // R7 / R8: a parked clock stays low
  a_r7_r8_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_div && !go) |=> !q_div);

  // R3: the divided path is silent in bypass
  a_r3_byp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    byp |-> (!q_div && !rise_q));

  // R4: a rising strobe comes with the clock high
  a_r4_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> q_div);

endmodule

// File: rtl/sdclk_outstage.sv
`timescale 1ns/1ps
module sdclk_outstage
  import sdclk_pkg::*;
#(
  parameter int unsigned LANES = CFG_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byp,
  input  logic             go,
  input  logic             q_div,
  input  logic             rise_q,
  input  logic             lch_q,
  input  logic [1:0]       width_sel,
  output logic             card_clk,
  output logic             clk_en,
  output logic             launch_stb,
  output logic [LANES-1:0] lane_en
);

  logic byp_gate_lo;
  logic byp_edge_q;

  // gate changes only while the kernel clock is low: no runt pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_gate_lo <= 1'b0;
    else        byp_gate_lo <= byp && go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_edge_q <= 1'b0;
    else        byp_edge_q <= byp_gate_lo;
  end

  assign card_clk   = byp_gate_lo ? clk : q_div;
  assign clk_en     = rise_q | byp_edge_q;
  assign launch_stb = lch_q  | byp_edge_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_en[i] <= (i == 0);
      else        lane_en[i] <= lane_pick(i, width_sel);
    end
  end

  // R9: only 1, 4 or all lanes are ever enabled
  a_r9_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_en) == 1) || ($countones(lane_en) == 4) ||
    ($countones(lane_en) == LANES));

  // R3: divided strobes never overlap a bypass edge
  a_r3_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
    byp_edge_q |-> !rise_q);

endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int unsigned DIV_W = CFG_DIV_W,
  parameter int unsigned LANES = CFG_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             neg_edge,
  input  logic             pwr_save,
  input  logic             bus_busy,
  input  logic             fifo_stall,
  input  logic [1:0]       width_sel,
  output logic             card_clk,
  output logic             clk_en,
  output logic             launch_stb,
  output logic [LANES-1:0] lane_en
);

  logic             go;
  logic             load;
  logic             q_div;
  logic             rise_q;
  logic             lch_q;
  logic             byp;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_neg;

  assign go = clock_go(run_en, fifo_stall, pwr_save, bus_busy);

  sdclk_shadow #(.DIV_W(DIV_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .q_div   (q_div),
    .div_in  (div_val),
    .neg_in  (neg_edge),
    .cfg_div (cfg_div),
    .cfg_neg (cfg_neg),
    .byp     (byp)
  );

  sdclk_divcore #(.DIV_W(DIV_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .go        (go),
    .byp       (byp),
    .cfg_div   (cfg_div),
    .cfg_neg   (cfg_neg),
    .q_div     (q_div),
    .rise_q    (rise_q),
    .lch_q     (lch_q),
    .low_bound (load)
  );

  sdclk_outstage #(.LANES(LANES)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .byp        (byp),
    .go         (go),
    .q_div      (q_div),
    .rise_q     (rise_q),
    .lch_q      (lch_q),
    .width_sel  (width_sel),
    .card_clk   (card_clk),
    .clk_en     (clk_en),
    .launch_stb (launch_stb),
    .lane_en    (lane_en)
  );

endmodule

// File: tb/sdclk_gen_tb.sv
`timescale 1ns/1ps
module sdclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [9:0] div_val = '0;
  logic       neg_edge = 1'b0;
  logic       pwr_save = 1'b0;
  logic       bus_busy = 1'b1;
  logic       fifo_stall = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic       card_clk, clk_en, launch_stb;
  logic [7:0] lane_en;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;
  bit mon_busy = 0;

  typedef struct { int half; bit neg; string tag; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  sdclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_val(div_val),
    .neg_edge(neg_edge), .pwr_save(pwr_save), .bus_busy(bus_busy),
    .fifo_stall(fifo_stall), .width_sel(width_sel), .card_clk(card_clk),
    .clk_en(clk_en), .launch_stb(launch_stb), .lane_en(lane_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp();       // sample point in the kernel high phase
    @(posedge clk); #1;
  endtask

  task automatic drv();       // drive point, clear of both edges
    @(posedge clk); #3;
  endtask

  task automatic wait_low();
    for (int n = 0; n < 5000 && card_clk; n++) smp();
  endtask

  task automatic wait_high();
    for (int n = 0; n < 5000 && !card_clk; n++) smp();
  endtask

  task automatic count_lvl(input bit lvl, output int n);
    n = 0;
    while (card_clk == lvl && n < 5000) begin n++; smp(); end
  endtask

  // monitor: pops an expected period and measures it
  initial begin
    exp_t e;
    int hi, lo;
    bit en_r, l_r, l_f;
    forever begin
      wait (sb_q.size() > 0);
      mon_busy = 1;
      e = sb_q.pop_front();
      smp(); wait_low(); wait_high();   // skip a period on old settings
      wait_low(); wait_high();
      en_r = clk_en; l_r = launch_stb;
      count_lvl(1'b1, hi);
      l_f = launch_stb;
      count_lvl(1'b0, lo);
      chk({"R2 high ", e.tag}, hi, e.half);
      chk({"R2 low ", e.tag}, lo, e.half);
      chk({"R4 clk_en at rise ", e.tag}, int'(en_r), 1);
      chk({"R4 launch at rise ", e.tag}, int'(l_r), int'(!e.neg));
      chk({"R4 launch at fall ", e.tag}, int'(l_f), int'(e.neg));
      mon_busy = 0;
    end
  end

  task automatic push_period(input int n, input bit ng, input string tag);
    exp_t e;
    drv(); div_val = 10'(n); neg_edge = ng;
    e.half = n; e.neg = ng; e.tag = tag;
    sb_q.push_back(e);
    #0 wait (sb_q.size() == 0 && !mon_busy);
  endtask

  function automatic int lanes_for(input logic [1:0] code);
    if (code[1])      return 255;
    else if (code[0]) return 15;
    return 1;
  endfunction

  // stop request in a high phase, then release; N = current divide value
  task automatic park_case(input int n, input bit use_stall, input string req);
    int hi, bad, lo;
    wait_low(); wait_high();
    #2;
    if (use_stall) fifo_stall = 1'b1; else begin pwr_save = 1'b1; bus_busy = 1'b0; end
    count_lvl(1'b1, hi);
    chk({req, " high phase completes"}, hi, n);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (card_clk || clk_en) bad++;
      smp();
    end
    chk({req, " parked low"}, bad, 0);
    drv();
    if (use_stall) fifo_stall = 1'b0; else bus_busy = 1'b1;
    lo = 0;
    smp();
    while (!card_clk && lo < 5000) begin lo++; smp(); end
    chk({req, " resume delay"}, lo, n - 1);
    pwr_save = 1'b0;
  endtask

  initial begin
    int hi, lo, bad;
    repeat (3) @(posedge clk);
    #6;
    chk("R1 reset card_clk", int'(card_clk), 0);
    chk("R1 reset clk_en", int'(clk_en), 0);
    chk("R1 reset launch", int'(launch_stb), 0);
    chk("R1 reset lanes", int'(lane_en), 1);
    drv(); rst_n = 1'b1;
    smp();
    chk("R1 after reset card_clk", int'(card_clk), 0);
    chk("R1 after reset lanes", int'(lane_en), 1);

    // R3 bypass
    drv(); run_en = 1'b1;
    repeat (3) smp();
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      smp();
      if (!card_clk || !clk_en || !launch_stb) bad++;
      @(negedge clk); #1;
      if (card_clk) bad++;
    end
    chk("R3 bypass follows kernel clock", bad, 0);

    // R6 in bypass
    drv(); run_en = 1'b0;
    @(negedge clk); #1;
    chk("R6 bypass low phase off", int'(card_clk), 0);
    smp();
    chk("R6 bypass card_clk off", int'(card_clk), 0);
    chk("R6 bypass clk_en off", int'(clk_en), 0);
    drv(); run_en = 1'b1;

    // R9 lane mask
    for (int c = 0; c < 4; c++) begin
      drv(); width_sel = 2'(c);
      smp();
      chk($sformatf("R9 lanes code %0d", c), int'(lane_en), lanes_for(2'(c)));
    end
    drv(); width_sel = 2'b00;

    // R2 / R4 scoreboard
    push_period(1, 1'b0, "n1");
    push_period(4, 1'b1, "n4 neg");
    push_period(7, 1'b0, "n7");
    push_period(2, 1'b1, "n2 neg");
    push_period(1023, 1'b1, "n1023 neg");

    // R5 reload in a high phase: old high, then new low and high
    drv(); div_val = 10'd3; neg_edge = 1'b0;
    smp(); wait_low(); wait_high(); wait_low(); wait_high();
    #2; div_val = 10'd6;
    count_lvl(1'b1, hi);
    count_lvl(1'b0, lo);
    chk("R5 high phase keeps old value", hi, 3);
    chk("R5 low phase takes new value", lo, 6);
    count_lvl(1'b1, hi);
    chk("R5 next high phase new value", hi, 6);

    // R6 in divided mode
    drv(); div_val = 10'd5;
    smp(); wait_low(); wait_high(); wait_low(); wait_high();
    #2; run_en = 1'b0;
    smp();
    chk("R6 divided off next edge", int'(card_clk), 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (card_clk || clk_en || launch_stb) bad++;
      smp();
    end
    chk("R6 stays off", bad, 0);
    drv(); run_en = 1'b1;

    // R7 power save, R8 flow-control stall
    drv(); div_val = 10'd4;
    smp(); wait_low(); wait_high();
    park_case(4, 1'b0, "R7");
    drv(); div_val = 10'd2;
    smp(); wait_low(); wait_high();
    park_case(2, 1'b1, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule